// File: doc/BRIEF.md
# Memory Target with Atomic Operations

This block is a memory endpoint on a request/response message fabric. A requester sends a message on the request channel. The message carries a 32-bit command header, a destination byte address, a source (return) address and a data payload. The block decodes the header and serves the request against an internal RAM of `DEPTH` words, each `DW` bits wide. It handles reads, acknowledged writes, posted writes and atomic read-modify-write operations. When a reply is due, it returns the reply on a separate response channel, sent to the address the requester gave as its source.

A burst of `LEN+1` words of `2^SIZE` bytes each is packed into the single data payload. Word k sits at payload byte `k<<SIZE`. The block accepts the message in one handshake and then walks the burst one word per clock cycle at consecutive addresses. It accepts no new request until the reply for the current one has left. Requests it cannot serve are taken off the channel and dropped, and a sticky error flag records that this happened. Callers give addresses aligned to the word size.

Top module: `umr_target`

## Requirements
- R1: The header fields decoded are opcode [4:0], SIZE [7:5], LEN [15:8] and end-of-message [22]; a request covers LEN+1 words of 2^SIZE bytes, with word k taken from payload byte k<<SIZE.
- R2: Opcode 0x01 (read) returns a reply with opcode 0x02 whose payload packs the LEN+1 words read, word k at byte k<<SIZE, with unused payload bytes zero.
- R3: Opcode 0x03 (acknowledged write) stores the words and returns a reply with opcode 0x04 and an all-zero payload.
- R4: Opcode 0x05 (posted write) stores the words and produces no reply.
- R5: Opcode 0x09 (atomic) takes its type from header bits [15:8]: 0 add, 1 AND, 2 OR, 3 XOR, 4 signed max, 5 signed min, 6 unsigned max, 7 unsigned min, 8 swap. The operand is payload word 0. The operation works at the 2^SIZE-byte width, with signed compares in two's complement at that width. The combined value is stored, and the old value is returned with opcode 0x02.
- R6: The reply destination address equals the request source address, and the reply source address equals the request destination address.
- R7: The reply header holds the reply opcode, the request SIZE, the request LEN (0 for atomics) and the request end-of-message bit; every other header bit is zero.
- R8: Burst word k is read from or written to byte address dst + k*2^SIZE.
- R9: A message moves only on a cycle with valid and ready both high. While a reply waits with ready low, all reply fields hold steady, and req_ready_o stays low until the reply is taken.
- R10: A request is dropped with no reply and no memory change when its opcode is not one of the four above, its atomic type exceeds 8, or its bytes ((LEN+1)<<SIZE, or 2^SIZE for atomics) exceed DW/8. A drop sets err_o, which stays high until reset.
- R11: Reset clears resp_valid_o and err_o and leaves req_ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_cmd_i | input | 32 | Request command header |
| req_dst_i | input | AW | Request destination byte address |
| req_src_i | input | AW | Request source (return) address |
| req_data_i | input | DW | Request payload |
| resp_valid_o | output | 1 | Reply valid |
| resp_ready_i | input | 1 | Reply ready |
| resp_cmd_o | output | 32 | Reply command header |
| resp_dst_o | output | AW | Reply destination address |
| resp_src_o | output | AW | Reply source address |
| resp_data_o | output | DW | Reply payload |
| err_o | output | 1 | Sticky flag for dropped requests |

## Verification
Assertions check on every cycle that a stalled reply holds all of its fields and that no request is accepted while a reply is pending. They also check that every reply carries one of the two reply opcodes, that a posted write never raises a reply, that a dropped request never starts work, and that the error flag never falls. The ALU carries a bound check on unsigned max. Data correctness can only be shown by the bench's scenarios: packed burst reads, lane placement of sub-word writes, each atomic type at full and half width with signed operands, the swap of return addresses, and the absence of side effects from dropped requests.

// File: rtl/umr_pkg.sv
package umr_pkg;
  localparam logic [4:0] OP_RD     = 5'h01;
  localparam logic [4:0] OP_RD_RSP = 5'h02;
  localparam logic [4:0] OP_WR     = 5'h03;
  localparam logic [4:0] OP_WR_ACK = 5'h04;
  localparam logic [4:0] OP_POST   = 5'h05;
  localparam logic [4:0] OP_AMO    = 5'h09;

  localparam logic [3:0] AMO_ADD  = 4'h0;
  localparam logic [3:0] AMO_AND  = 4'h1;
  localparam logic [3:0] AMO_OR   = 4'h2;
  localparam logic [3:0] AMO_XOR  = 4'h3;
  localparam logic [3:0] AMO_MAX  = 4'h4;
  localparam logic [3:0] AMO_MIN  = 4'h5;
  localparam logic [3:0] AMO_MAXU = 4'h6;
  localparam logic [3:0] AMO_MINU = 4'h7;
  localparam logic [3:0] AMO_SWAP = 4'h8;

  typedef struct packed {
    logic [4:0] hostid;
    logic [1:0] user;
    logic       ex;
    logic       eof;
    logic       eom;
    logic [1:0] prot;
    logic [3:0] qos;
    logic [7:0] len;
    logic [2:0] size;
    logic [4:0] opcode;
  } hdr_t;
endpackage

// File: rtl/umr_ram.sv
module umr_ram #(
  parameter int DW    = 64,
  parameter int DEPTH = 64,
  localparam int NB   = DW / 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [IW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[b]) mem_q[addr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/umr_amo_alu.sv
module umr_amo_alu #(
  parameter int DW = 64
) (
  input  logic [3:0]    op_i,
  input  logic [2:0]    size_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  import umr_pkg::*;

  logic [DW-1:0] m, am, bm, as, bs, r;
  int sbits;

  always_comb begin
    sbits = 8 << size_i;
    if (sbits > DW) sbits = DW;
    m  = {DW{1'b1}} >> (DW - sbits);
    am = a_i & m;
    bm = b_i & m;
    // sign-extend at the operand width
    as = am | (am[sbits-1] ? ~m : '0);
    bs = bm | (bm[sbits-1] ? ~m : '0);
    unique case (op_i)
      AMO_ADD:  r = am + bm;
      AMO_AND:  r = am & bm;
      AMO_OR:   r = am | bm;
      AMO_XOR:  r = am ^ bm;
      AMO_MAX:  r = ($signed(as) > $signed(bs)) ? am : bm;
      AMO_MIN:  r = ($signed(as) < $signed(bs)) ? am : bm;
      AMO_MAXU: r = (am > bm) ? am : bm;
      AMO_MINU: r = (am < bm) ? am : bm;
      AMO_SWAP: r = bm;
      default:  r = am;
    endcase
    res_o = r & m;
  end

  always_comb begin
    if (op_i == AMO_MAXU) begin
      AST_MAXU_BOUND: assert (res_o >= am && res_o >= bm); // R5
    end
  end
endmodule

// File: rtl/umr_target.sv
module umr_target #(
  parameter int DW    = 64,
  parameter int AW    = 32,
  parameter int DEPTH = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_cmd_i,
  input  logic [AW-1:0] req_dst_i,
  input  logic [AW-1:0] req_src_i,
  input  logic [DW-1:0] req_data_i,
  output logic          resp_valid_o,
  input  logic          resp_ready_i,
  output logic [31:0]   resp_cmd_o,
  output logic [AW-1:0] resp_dst_o,
  output logic [AW-1:0] resp_src_o,
  output logic [DW-1:0] resp_data_o,
  output logic          err_o
);
  import umr_pkg::*;

  localparam int NB  = DW / 8;
  localparam int OFF = $clog2(NB);
  localparam int IW  = $clog2(DEPTH);

  typedef enum logic [1:0] {ST_IDLE, ST_WORK, ST_RESP} st_e;

  st_e           st_q;
  hdr_t          hdr_in, hdr_q, rsp_hdr;
  logic [AW-1:0] dst_q, src_q, addr;
  logic [DW-1:0] wd_q, acc_q;
  logic [7:0]    idx_q;
  logic          err_q;

  // request legality
  logic [15:0] in_bytes;
  logic        in_amo, op_ok, fits, req_ok, accept;

  assign hdr_in = hdr_t'(req_cmd_i);
  assign in_amo = hdr_in.opcode == OP_AMO;
  assign in_bytes = in_amo ? (16'd1 << hdr_in.size)
                           : ((16'(hdr_in.len) + 16'd1) << hdr_in.size);
  assign fits   = in_bytes <= 16'(NB);
  assign op_ok  = (hdr_in.opcode == OP_RD) || (hdr_in.opcode == OP_WR) ||
                  (hdr_in.opcode == OP_POST) || (in_amo && hdr_in.len <= 8'd8);
  assign req_ok = op_ok && fits;
  assign req_ready_o = st_q == ST_IDLE;
  assign accept = req_valid_i && req_ready_o;

  // per-word datapath
  logic          is_rd, is_amo, is_post, ram_we, last;
  logic [15:0]   boff;
  logic [OFF-1:0] lane;
  logic [IW-1:0] widx;
  logic [DW-1:0] smask, rdata, old, wword, amo_res, new_val, ram_wd;
  logic [NB-1:0] nbmask, ram_be;
  int            sbits, nbytes;

  assign is_rd   = hdr_q.opcode == OP_RD;
  assign is_amo  = hdr_q.opcode == OP_AMO;
  assign is_post = hdr_q.opcode == OP_POST;
  assign boff    = 16'(idx_q) << hdr_q.size;
  assign addr    = dst_q + AW'(boff);
  assign lane    = addr[OFF-1:0];
  assign widx    = addr[OFF+IW-1:OFF];
  assign last    = is_amo || (idx_q == hdr_q.len);

  always_comb begin
    nbytes = 1 << hdr_q.size;
    if (nbytes > NB) nbytes = NB;
    sbits  = nbytes * 8;
    smask  = {DW{1'b1}} >> (DW - sbits);
    nbmask = {NB{1'b1}} >> (NB - nbytes);
    old    = (rdata >> {lane, 3'b000}) & smask;
    wword  = (wd_q >> {boff, 3'b000}) & smask;
    new_val = is_amo ? amo_res : wword;
    ram_wd = new_val << {lane, 3'b000};
    ram_be = nbmask << lane;
  end

  assign ram_we = (st_q == ST_WORK) && !is_rd;

  umr_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .be_i   (ram_be),
    .addr_i (widx),
    .wdata_i(ram_wd),
    .rdata_o(rdata)
  );

  umr_amo_alu #(.DW(DW)) u_alu (
    .op_i  (hdr_q.len[3:0]),
    .size_i(hdr_q.size),
    .a_i   (old),
    .b_i   (wd_q),
    .res_o (amo_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      hdr_q <= '0;
      dst_q <= '0;
      src_q <= '0;
      wd_q  <= '0;
      acc_q <= '0;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (req_ok) begin
            hdr_q <= hdr_in;
            dst_q <= req_dst_i;
            src_q <= req_src_i;
            wd_q  <= req_data_i;
            acc_q <= '0;
            idx_q <= '0;
            st_q  <= ST_WORK;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_WORK: begin
          if (is_rd)  acc_q <= acc_q | (old << {boff, 3'b000});
          if (is_amo) acc_q <= old;
          if (last) st_q <= is_post ? ST_IDLE : ST_RESP;
          else      idx_q <= idx_q + 8'd1;
        end
        ST_RESP: if (resp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rsp_hdr        = '0;
    rsp_hdr.opcode = (hdr_q.opcode == OP_WR) ? OP_WR_ACK : OP_RD_RSP;
    rsp_hdr.size   = hdr_q.size;
    rsp_hdr.len    = is_amo ? 8'd0 : hdr_q.len;
    rsp_hdr.eom    = hdr_q.eom;
  end

  assign resp_valid_o = st_q == ST_RESP;
  assign resp_cmd_o   = rsp_hdr;
  assign resp_dst_o   = src_q;
  assign resp_src_o   = dst_q;
  assign resp_data_o  = acc_q;
  assign err_o        = err_q;

  AST_RESP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_ready_i |=> resp_valid_o && $stable(resp_cmd_o) &&
    $stable(resp_data_o) && $stable(resp_dst_o) && $stable(resp_src_o)); // R9
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o); // R9
  AST_RESP_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_cmd_o[4:0] == OP_RD_RSP) || (resp_cmd_o[4:0] == OP_WR_ACK)); // R7
  AST_POSTED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WORK) && last && is_post |=> !resp_valid_o); // R4
  AST_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !req_ok |=> st_q == ST_IDLE && err_o); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10
endmodule

// File: tb/umr_target_tb.sv
module umr_target_tb;
  localparam int CLK_P = 10;
  localparam int DW = 64, AW = 32, DEPTH = 64;
  localparam int MB = DEPTH * DW / 8;

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, resp_ready_i = 1;
  logic [31:0] req_cmd_i = '0;
  logic [AW-1:0] req_dst_i = '0, req_src_i = '0;
  logic [DW-1:0] req_data_i = '0;
  logic req_ready_o, resp_valid_o, err_o;
  logic [31:0] resp_cmd_o;
  logic [AW-1:0] resp_dst_o, resp_src_o;
  logic [DW-1:0] resp_data_o;

  umr_target #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, rdy_mode = 0, cyc = 0;
  logic [7:0] mem_m [MB];
  logic [31:0] q_cmd[$], q_dst[$], q_src[$];
  logic [63:0] q_data[$];
  string q_tag[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reply ready pattern
  always @(posedge clk_i) begin
    cyc++;
    #1;
    case (rdy_mode)
      0: resp_ready_i = 1'b1;
      1: resp_ready_i = cyc[0] ^ cyc[2];
      default: resp_ready_i = 1'b0;
    endcase
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && resp_valid_o && resp_ready_i) begin
      if (q_cmd.size() == 0) chk(0, "R4 unexpected reply", resp_cmd_o, 0);
      else begin
        string t;
        logic [31:0] ec, ed, es;
        logic [63:0] ev;
        t = q_tag.pop_front(); ec = q_cmd.pop_front();
        ed = q_dst.pop_front(); es = q_src.pop_front(); ev = q_data.pop_front();
        chk(resp_cmd_o == ec, {t, " R7 cmd"}, resp_cmd_o, ec);
        chk(resp_dst_o == ed && resp_src_o == es, {t, " R6 route"},
            {resp_dst_o, resp_src_o}, {ed, es});
        chk(resp_data_o == ev, {t, " data"}, resp_data_o, ev);
      end
    end
  end

  function automatic logic [31:0] mk_cmd(logic [4:0] op, int sz, int ln);
    logic [31:0] c;
    c = 32'ha80a_0000;         // hostid/qos noise, must not reach the reply
    c[4:0] = op; c[7:5] = 3'(sz); c[15:8] = 8'(ln); c[22] = 1'b1;
    return c;
  endfunction

  function automatic logic [31:0] rsp_cmd(logic [4:0] op, int sz, int ln);
    logic [31:0] c;
    c = '0; c[4:0] = op; c[7:5] = 3'(sz); c[15:8] = 8'(ln); c[22] = 1'b1;
    return c;
  endfunction

  function automatic logic [63:0] msk(int sz);
    return (sz >= 3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  function automatic longint sx(logic [63:0] v, int sz);
    int b;
    b = 8 << sz;
    if (b >= 64) return longint'(v);
    return longint'(v[b-1] ? (v | ~msk(sz)) : v);
  endfunction

  function automatic logic [63:0] m_rd(int a, int sz);
    logic [63:0] v;
    v = '0;
    for (int j = 0; j < (1 << sz); j++) v[j*8 +: 8] = mem_m[(a + j) % MB];
    return v;
  endfunction

  task automatic m_wr(int a, int sz, logic [63:0] v);
    for (int j = 0; j < (1 << sz); j++) mem_m[(a + j) % MB] = v[j*8 +: 8];
  endtask

  task automatic send(logic [31:0] c, int dst, int src, logic [63:0] d);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1; req_cmd_i = c; req_dst_i = dst; req_src_i = src; req_data_i = d;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic expect_rsp(string t, logic [31:0] c, int dst, int src, logic [63:0] d);
    q_tag.push_back(t); q_cmd.push_back(c);
    q_dst.push_back(src); q_src.push_back(dst); q_data.push_back(d);
  endtask

  task automatic do_read(string t, int sz, int ln, int dst, int src);
    logic [63:0] e;
    e = '0;
    for (int k = 0; k <= ln; k++) e[(k << sz)*8 +: 64] = m_rd(dst + (k << sz), sz);
    expect_rsp(t, rsp_cmd(5'h02, sz, ln), dst, src, e);
    send(mk_cmd(5'h01, sz, ln), dst, src, 64'hdead_beef_0bad_f00d);
  endtask

  task automatic do_write(string t, bit posted, int sz, int ln, int dst, int src, logic [63:0] d);
    for (int k = 0; k <= ln; k++)
      m_wr(dst + (k << sz), sz, (d >> ((k << sz)*8)) & msk(sz));
    if (!posted) expect_rsp(t, rsp_cmd(5'h04, sz, ln), dst, src, '0);
    send(mk_cmd(posted ? 5'h05 : 5'h03, sz, ln), dst, src, d);
  endtask

  task automatic do_amo(string t, int ty, int sz, int dst, int src, logic [63:0] b);
    logic [63:0] o, bm, r;
    o = m_rd(dst, sz); bm = b & msk(sz);
    case (ty)
      0: r = o + bm;  1: r = o & bm;  2: r = o | bm;  3: r = o ^ bm;
      4: r = (sx(o, sz) > sx(bm, sz)) ? o : bm;
      5: r = (sx(o, sz) < sx(bm, sz)) ? o : bm;
      6: r = (o > bm) ? o : bm;
      7: r = (o < bm) ? o : bm;
      default: r = bm;
    endcase
    m_wr(dst, sz, r & msk(sz));
    expect_rsp(t, rsp_cmd(5'h02, sz, 0), dst, src, o);
    send(mk_cmd(5'h09, sz, ty), dst, src, b);
  endtask

  task automatic drain();
    int w;
    w = 0;
    while ((q_cmd.size() != 0 || !req_ready_o) && w < 200) begin
      @(negedge clk_i); w++;
    end
    repeat (3) @(negedge clk_i);
    chk(q_cmd.size() == 0, "R9 reply delivered", q_cmd.size(), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [63:0] hold;
    repeat (3) @(negedge clk_i);
    chk(resp_valid_o == 0 && err_o == 0 && req_ready_o == 1, "R11 reset state",
        {resp_valid_o, err_o, req_ready_o}, 3'b001);
    rst_ni = 1;
    // R4: fill memory with posted full-width writes
    for (int i = 0; i < DEPTH; i++)
      do_write("R4 fill", 1, 3, 0, i * 8, 0, {32'(i) ^ 32'h5a5a_0000, 32'(i * 7 + 3)});
    drain();
    // R2 single word, R8 bursts, R1 byte packing
    do_read("R2 rd64", 3, 0, 8'h18, 32'h4000);
    do_read("R8 rd32x2", 2, 1, 8'h20, 32'h4004);
    do_read("R1 rd8x8", 0, 7, 8'h30, 32'h0077);
    do_read("R8 rd16x3", 1, 2, 8'h42, 32'h0100);
    drain();
    // R3 acknowledged sub-word burst, then read back
    do_write("R3 wr16x4", 0, 1, 3, 8'h50, 32'h0200, 64'h1122_3344_5566_7788);
    do_write("R4 post8", 1, 0, 1, 8'h63, 32'h0300, 64'h0000_0000_0000_a5c3);
    rdy_mode = 1;
    do_read("R3 readback", 3, 0, 8'h50, 32'h0201);
    do_read("R4 readback", 3, 0, 8'h60, 32'h0301);
    drain();
    // R5 atomics at full width
    do_write("R5 seed", 1, 3, 0, 8'h80, 0, 64'h8000_0000_0000_0010);
    for (int t = 0; t <= 8; t++)
      do_amo($sformatf("R5 amo64 t%0d", t), t, 3, 8'h80, 32'h0500 + t,
             64'h0000_0000_0000_0f3c + 64'(t) * 64'h1_0000_0001);
    do_read("R5 amo64 final", 3, 0, 8'h80, 32'h0510);
    // R5 half width in upper lane, signed versus unsigned
    do_write("R5 seed32", 1, 2, 1, 8'h88, 0, 64'h8000_0000_7fff_fff0);
    do_amo("R5 smax32", 4, 2, 8'h8c, 32'h0600, 64'hffff_ffff_0000_0005);
    do_amo("R5 umax32", 6, 2, 8'h88, 32'h0601, 64'h0000_0000_8000_0001);
    do_amo("R5 smin32", 5, 2, 8'h88, 32'h0602, 64'h0000_0000_ffff_fffe);
    do_amo("R5 add8", 0, 0, 8'h8b, 32'h0603, 64'h0000_0000_0000_00f1);
    do_read("R5 amo32 final", 3, 0, 8'h88, 32'h0604);
    drain();
    // R9 stall: reply held while ready low, no new request accepted
    rdy_mode = 2;
    do_read("R9 stalled", 3, 0, 8'h10, 32'h0700);
    repeat (4) @(negedge clk_i);
    hold = resp_data_o;
    chk(resp_valid_o == 1 && req_ready_o == 0, "R9 pending blocks requests",
        {resp_valid_o, req_ready_o}, 2'b10);
    repeat (3) @(negedge clk_i);
    chk(resp_valid_o == 1 && resp_data_o == hold, "R9 fields stable", resp_data_o, hold);
    rdy_mode = 0;
    drain();
    // R10 drops: bad opcode, bad atomic type, oversize burst
    chk(err_o == 0, "R10 err clear before drop", err_o, 0);
    send(mk_cmd(5'h07, 3, 0), 8'h40, 32'h0800, 64'hffff_ffff_ffff_ffff);
    chk(err_o == 1, "R10 err set by bad opcode", err_o, 1);
    send(mk_cmd(5'h09, 3, 9), 8'h40, 32'h0801, 64'hffff_ffff_ffff_ffff);
    send(mk_cmd(5'h03, 3, 1), 8'h40, 32'h0802, 64'hffff_ffff_ffff_ffff);
    send(mk_cmd(5'h01, 2, 2), 8'h40, 32'h0803, 64'h0);
    repeat (6) @(negedge clk_i);
    chk(resp_valid_o == 0 && err_o == 1, "R10 no reply, flag sticky",
        {resp_valid_o, err_o}, 2'b01);
    do_read("R10 memory untouched", 3, 1 - 1, 8'h40, 32'h0804);
    drain();
    // R11 reset clears flag
    rst_ni = 0;
    @(negedge clk_i);
    chk(err_o == 0 && resp_valid_o == 0 && req_ready_o == 1, "R11 reset clears",
        {err_o, resp_valid_o, req_ready_o}, 3'b001);
    rst_ni = 1;
    do_read("R11 after reset", 3, 0, 8'h80, 32'h0900);
    drain();
    finish_run();
  end
endmodule